// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the addresses of a four-beat burst from one base address. A load strobe captures an external address and starts a burst at it. Each step strobe then moves to the next beat. The two low address bits follow one of two orderings, chosen by a static select input. The upper address bits stay at the loaded value for the whole burst. The block reports the full current address and the index of the current beat.

A surrounding control unit decodes its own bus strobes into load and step commands and uses the address to reach memory. The sequencer keeps only the burst position. It stores the loaded start offset and a beat counter, and it forms the low address bits from the two:
- In linear order (select low) the low bits are the offset plus the beat, modulo 4.
- In interleaved order (select high) the low bits are the offset XOR the beat.

After the fourth beat the sequence wraps to its start. A load at any time abandons the burst in progress.

The control state machine has two states:
- `ST_IDLE`: no burst has been loaded since reset. Steps are ignored in this state.
- `ST_RUN`: a burst is active.

It has three named transitions:
- LOAD: from either state to `ST_RUN`. It captures the base address and clears the beat counter.
- STEP: `ST_RUN` to `ST_RUN`. It increments the beat counter.
- HOLD: `ST_RUN` to `ST_RUN` with no strobe. All registers keep their values.

Reset forces `ST_IDLE`.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `addr_o` is 0 and `beat_o` is 0.
- R2: A clock edge with `load_i` high makes `addr_o` equal to `base_addr_i` and `beat_o` equal to 0 from the next cycle.
- R3: With `order_il_i` = 0 (linear), each step sets the low two address bits to (start + beat) mod 4. From start 01 the order is 01,10,11,00.
- R4: With `order_il_i` = 1 (interleaved), each step sets the low two address bits to start XOR beat. From start 01 the order is 01,00,11,10.
- R5: Address bits above bit 1 keep the loaded value through steps and holds.
- R6: In `ST_RUN`, an edge with both `load_i` and `step_i` low leaves `addr_o` and `beat_o` unchanged.
- R7: The step after the fourth beat returns the address to the loaded start address, with `beat_o` equal to 0.
- R8: A load during a burst restarts at the new base address with beat 0. Load wins over a step in the same cycle.
- R9: In `ST_IDLE`, before any load after reset, `step_i` has no effect: `addr_o` and `beat_o` stay 0.
- R10: `beat_o` goes up by exactly 1, modulo 4, on each step in `ST_RUN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture `base_addr_i` and start a burst |
| step_i | input | 1 | Advance to the next beat |
| order_il_i | input | 1 | Static ordering select: 0 linear, 1 interleaved |
| base_addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | BEAT_W | Current beat index |

## Verification
The bound checker checks several rules on every cycle:
- A load yields the base address and beat 0 on the next cycle.
- A cycle with no strobe holds the address and beat.
- The upper bits change only on a load.
- Steps before the first load are ignored.
- Each step adds one to the beat and changes the low bits by the rule of the selected ordering: +1 for linear, a XOR pattern matching the beat change for interleaved.

Only the bench's scenarios show the following:
- The exact four-address orders from each of the four start offsets in both modes.
- The wrap back to the start address.
- Load winning over a simultaneous step.
- The reset values.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } seq_order_t;

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-BEAT_W-1:0] upper_o,
    output logic [BEAT_W-1:0] start_o,
    output logic [BEAT_W-1:0] beat_o
);

    localparam int UP_W = ADDR_W - BEAT_W;

    seq_state_t state_q, state_d;
    logic [UP_W-1:0]   upper_q;
    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] beat_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: LOAD from any state, STEP/HOLD stay in ST_RUN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_i) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // Burst registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            beat_q  <= '0;
        end else if (load_i) begin
            upper_q <= base_i[ADDR_W-1:BEAT_W];
            start_q <= base_i[BEAT_W-1:0];
            beat_q  <= '0;
        end else if (step_i && (state_q == ST_RUN)) begin
            beat_q  <= beat_q + 1'b1;
        end
    end

    assign upper_o = upper_q;
    assign start_o = start_q;
    assign beat_o  = beat_q;

endmodule

// File: rtl/bseq_order.sv
module bseq_order
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              order_il_i,
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [BEAT_W-1:0] off_o
);

    seq_order_t ord;
    assign ord = seq_order_t'(order_il_i);

    always_comb begin
        unique case (ord)
            ORD_LINEAR:     off_o = start_i + beat_i;
            ORD_INTERLEAVE: off_o = start_i ^ beat_i;
            default:        off_o = start_i;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              order_il_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BEAT_W-1:0] beat_o
);

    localparam int UP_W = ADDR_W - BEAT_W;

    logic [UP_W-1:0]   upper;
    logic [BEAT_W-1:0] start;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] off;

    bseq_ctrl #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .step_i  (step_i),
        .base_i  (base_addr_i),
        .upper_o (upper),
        .start_o (start),
        .beat_o  (beat)
    );

    bseq_order #(.BEAT_W(BEAT_W)) u_order (
        .order_il_i (order_il_i),
        .start_i    (start),
        .beat_i     (beat),
        .off_o      (off)
    );

    assign addr_o = {upper, off};
    assign beat_o = beat;

endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic              step_i,
    input logic              order_il_i,
    input logic [ADDR_W-1:0] base_addr_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [BEAT_W-1:0] beat_o
);

    logic seen_load;
    always_ff @(posedge clk) begin
        if (!rst_n)      seen_load <= 1'b0;
        else if (load_i) seen_load <= 1'b1;
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o == $past(base_addr_i)) && (beat_o == '0));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_load && !load_i && !step_i) |=> $stable(addr_o) && $stable(beat_o));

    assert_upper_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

    assert_idle_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_load && !load_i) |=> $stable(addr_o) && $stable(beat_o));

    assert_beat_inc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_load && step_i && !load_i) |=> beat_o == BEAT_W'($past(beat_o) + 1'b1));

    assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_load && step_i && !load_i && !order_il_i) |=>
        addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1));

    assert_interleave_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_load && step_i && !load_i && order_il_i) |=>
        (addr_o[BEAT_W-1:0] ^ $past(addr_o[BEAT_W-1:0])) == (beat_o ^ $past(beat_o)));

endmodule

bind burst_addr_seq bseq_checker #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_bseq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .step_i      (step_i),
    .order_il_i  (order_il_i),
    .base_addr_i (base_addr_i),
    .addr_o      (addr_o),
    .beat_o      (beat_o)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;

    localparam int AW = 20;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic          step_i = 1'b0;
    logic          order_il_i = 1'b0;
    logic [AW-1:0] base_addr_i = '0;
    logic [AW-1:0] addr_o;
    logic [BW-1:0] beat_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) i_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step_i),
        .order_il_i(order_il_i), .base_addr_i(base_addr_i),
        .addr_o(addr_o), .beat_o(beat_o)
    );

    task automatic check(input string tag, input logic [AW-1:0] got_a,
                         input logic [AW-1:0] exp_a, input logic [BW-1:0] got_b,
                         input logic [BW-1:0] exp_b);
        checks++;
        if (got_a !== exp_a || got_b !== exp_b) begin
            errors++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     tag, got_a, got_b, exp_a, exp_b);
        end
    endtask

    // Apply inputs for one edge; on return the outputs reflect that edge.
    task automatic cyc(input logic l, input logic s, input logic [AW-1:0] b);
        load_i = l; step_i = s; base_addr_i = b;
        @(negedge clk);
        load_i = 1'b0; step_i = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 during reset", addr_o, '0, beat_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", addr_o, '0, beat_o, '0);
    endtask

    task automatic t_idle_step;
        cyc(1'b0, 1'b1, 20'hABCDE);
        check("R9 step before load", addr_o, '0, beat_o, '0);
        cyc(1'b0, 1'b1, 20'h12345);
        check("R9 second step before load", addr_o, '0, beat_o, '0);
    endtask

    task automatic t_order(input logic il);
        order_il_i = il;
        for (int s = 0; s < 4; s++) begin
            logic [AW-1:0] base;
            logic [AW-1:0] upper;
            upper = AW'(20'h5A3C0 + (s << 4));
            base  = upper | AW'(s);
            cyc(1'b1, 1'b0, base);
            check("R2 load", addr_o, base, beat_o, '0);
            for (int k = 1; k <= 4; k++) begin
                logic [BW-1:0] lo;
                lo = il ? BW'(s ^ (k % 4)) : BW'((s + k) % 4);
                cyc(1'b0, 1'b1, 20'hFFFFF);
                if (k == 4)
                    check("R7 wrap to start", addr_o, base, beat_o, '0);
                else if (il)
                    check("R4 R5 R10 interleaved beat", addr_o, upper | AW'(lo),
                          beat_o, BW'(k));
                else
                    check("R3 R5 R10 linear beat", addr_o, upper | AW'(lo),
                          beat_o, BW'(k));
            end
        end
    endtask

    task automatic t_hold;
        order_il_i = 1'b0;
        cyc(1'b1, 1'b0, 20'h00F01);
        cyc(1'b0, 1'b1, 20'h0);
        check("R3 step before hold", addr_o, 20'h00F02, beat_o, 2'd1);
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b0, 20'h77777);
            check("R6 hold", addr_o, 20'h00F02, beat_o, 2'd1);
        end
        cyc(1'b0, 1'b1, 20'h0);
        check("R6 resume after hold", addr_o, 20'h00F03, beat_o, 2'd2);
    endtask

    task automatic t_reload;
        order_il_i = 1'b1;
        cyc(1'b1, 1'b0, 20'h11112);
        cyc(1'b0, 1'b1, 20'h0);
        cyc(1'b0, 1'b1, 20'h0);
        check("R4 mid burst", addr_o, 20'h11110, beat_o, 2'd2);
        cyc(1'b1, 1'b1, 20'h22223);
        check("R8 reload wins over step", addr_o, 20'h22223, beat_o, 2'd0);
        cyc(1'b0, 1'b1, 20'h0);
        check("R8 new burst continues", addr_o, 20'h22222, beat_o, 2'd1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_idle_step();
        t_order(1'b0);
        t_order(1'b1);
        t_hold();
        t_reload();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule